// File: doc/BRIEF.md
# Sign-Bit Cyclic-Prefix Timing Synchronizer

This block gives a coarse estimate of where an OFDM symbol starts, using nothing but the sign bit of each in-phase and quadrature sample. Each incoming sample is correlated with the sample that arrived one FFT length earlier. The products are summed over a sliding window as long as the cyclic prefix. The block then reports the position where this windowed correlation is largest within a search span set by software. Because each stored sample is only two bits wide, the delay memory and the window history stay small. The FFT length, the window length and the search span are all run-time inputs, so one instance can serve standards with FFT sizes from 64 to 2048.

A search starts with a one-cycle `start` pulse. The first `fft_len` valid samples after the pulse only load the delay line. The next `search_len` valid samples each produce one metric evaluation, numbered from 0. After the last evaluation the block raises `done` for one cycle. In that same cycle `timing_est` carries the number of the winning evaluation, and it keeps that value until the next search completes.

The control path is a four-state machine:
- IDLE is the state after reset.
- FILL loads the delay line.
- SEARCH evaluates metrics.
- DONE holds the result.

Its transitions are:
- "arm": IDLE to FILL on `start`.
- "primed": FILL to SEARCH on the `fft_len`-th valid sample.
- "finish": SEARCH to DONE on the `search_len`-th evaluation.
- "restart": any state to FILL on `start`.

Top module: `cp_sign_sync`

## Requirements
- R1: After reset, `done` is 0 and `timing_est` is 0, and the block waits in IDLE.
- R2: A sign bit of 1 stands for -1 and a sign bit of 0 stands for +1. Evaluation j uses the complex product r(N+j)·conj(r(j)), where r(k) is the k-th valid sample after start and N is `fft_len`. The metric is |Re S| + |Im S|, where S is the windowed sum of these products.
- R3: The correlation lag is exactly `fft_len` valid samples. The first `fft_len` samples after start produce no evaluation.
- R4: S for evaluation j sums the products of evaluations max(0, j-L+1) through j, where L is `cp_len` (1 to LMAX). Early evaluations therefore use partial windows.
- R5: `timing_est` is the evaluation index with the largest metric among indices 0 to `search_len`-1. When several indices share the largest value, the lowest of them is reported.
- R6: `done` is high for exactly one cycle: the cycle right after the clock edge that captures the `search_len`-th evaluation sample. `timing_est` changes only in that cycle and otherwise holds its value. `search_len` must be at least 1.
- R7: Cycles with `in_valid` low are skipped. Inserting gaps does not change the result.
- R8: `start` restarts the search from any state. The sample offered in the start cycle is discarded, and an aborted search never produces `done`.
- R9: Valid samples that arrive before any start, or after a search has finished, produce no `done` and leave `timing_est` unchanged.
- R10: `fft_len` may be set to any value from 64 to NMAX (2048 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a new search |
| in_valid | input | 1 | The sample sign bits are valid this cycle |
| in_i_sgn | input | 1 | Sign bit of the in-phase sample (1 = negative) |
| in_q_sgn | input | 1 | Sign bit of the quadrature sample (1 = negative) |
| fft_len | input | $clog2(NMAX)+1 | Correlation lag in samples |
| cp_len | input | $clog2(LMAX)+1 | Moving-sum window length |
| search_len | input | SRCH_W | Number of metric evaluations in one search |
| done | output | 1 | One-cycle pulse when the result is ready |
| timing_est | output | SRCH_W | Index of the evaluation with the peak metric |

## Verification
Two pairs of events can coincide, and the bench forces each of them.

The first pair is a start pulse and a valid sample in the same cycle. Every search is launched with `in_valid` high and an arbitrary sample during the start cycle. A second search also starts while the first one is still in SEARCH. The checks require that the start-cycle sample is never counted, that the aborted search yields no result, and that the scoreboard sees only the expected result.

The second pair is the final evaluation setting a new peak in the same cycle the result is latched. A constant stream with `search_len` equal to `cp_len` makes the last index the winner. The check requires that `timing_est` already shows that last index in the `done` cycle.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_SEARCH = 2'd2,
        ST_DONE   = 2'd3
    } sync_state_t;

    // Half-scaled complex product of two sign-only samples: each part in {-1,0,+1}
    typedef struct packed {
        logic signed [1:0] re;
        logic signed [1:0] im;
    } half_prod_t;

    // new * conj(old) using equality of sign bits; a matching pair contributes +1
    function automatic half_prod_t sign_corr(input logic i_n, input logic q_n,
                                             input logic i_d, input logic q_d);
        half_prod_t p;
        logic eq_ii, eq_qq, eq_qi, eq_iq;
        eq_ii = ~(i_n ^ i_d);
        eq_qq = ~(q_n ^ q_d);
        eq_qi = ~(q_n ^ i_d);
        eq_iq = ~(i_n ^ q_d);
        if (eq_ii && eq_qq)        p.re = 2'sb01;
        else if (!eq_ii && !eq_qq) p.re = 2'sb11;
        else                       p.re = 2'sb00;
        if (eq_qi && !eq_iq)       p.im = 2'sb01;
        else if (!eq_qi && eq_iq)  p.im = 2'sb11;
        else                       p.im = 2'sb00;
        return p;
    endfunction

endpackage

// File: rtl/cps_delay.sv
`timescale 1ns/1ps
module cps_delay #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH),
    parameter int LENW  = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            push,
    input  logic [LENW-1:0] len,
    input  logic [1:0]      din,
    output logic [1:0]      dout
);
    logic [1:0]    mem [DEPTH];
    logic [AW-1:0] ptr;
    logic          wrap;

    assign wrap = ({1'b0, ptr} == (len - 1'b1));
    assign dout = mem[ptr];   // read before overwrite: the sample one lag back

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (push) begin
            ptr <= wrap ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[ptr] <= din;
        end
    end
endmodule

// File: rtl/cps_movsum.sv
`timescale 1ns/1ps
module cps_movsum
    import cps_pkg::*;
#(
    parameter int LMAX = 512,
    parameter int HAW  = $clog2(LMAX),
    parameter int LENW = HAW + 1,
    parameter int SW   = $clog2(LMAX + 1) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push,
    input  logic                 drop,
    input  logic [LENW-1:0]      len,
    input  half_prod_t           prod,
    output logic signed [SW-1:0] sum_re,
    output logic signed [SW-1:0] sum_im,
    output logic signed [SW-1:0] nxt_re,
    output logic signed [SW-1:0] nxt_im
);
    half_prod_t     hist [LMAX];
    half_prod_t     leaving;
    logic [HAW-1:0] hptr;
    logic           wrap;
    logic signed [SW-1:0] add_re, add_im, sub_re, sub_im;

    assign wrap    = ({1'b0, hptr} == (len - 1'b1));
    assign leaving = hist[hptr];
    assign add_re  = {{(SW-2){prod.re[1]}}, prod.re};
    assign add_im  = {{(SW-2){prod.im[1]}}, prod.im};
    assign sub_re  = drop ? {{(SW-2){leaving.re[1]}}, leaving.re} : '0;
    assign sub_im  = drop ? {{(SW-2){leaving.im[1]}}, leaving.im} : '0;
    assign nxt_re  = sum_re + add_re - sub_re;
    assign nxt_im  = sum_im + add_im - sub_im;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hptr   <= '0;
            sum_re <= '0;
            sum_im <= '0;
        end else if (push) begin
            hptr   <= wrap ? '0 : hptr + 1'b1;
            sum_re <= nxt_re;
            sum_im <= nxt_im;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            hist[hptr] <= prod;
        end
    end
endmodule

// File: rtl/cps_peak.sv
`timescale 1ns/1ps
module cps_peak #(
    parameter int MW = 12,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          eval,
    input  logic [MW-1:0] metric,
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] win_idx
);
    logic [MW-1:0] best_m;
    logic [IW-1:0] best_i;
    logic          beats;

    // strictly greater: an equal later metric never displaces the earlier index
    assign beats   = eval && (metric > best_m);
    assign win_idx = beats ? idx : best_i;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_m <= '0;
            best_i <= '0;
        end else if (beats) begin
            best_m <= metric;
            best_i <= idx;
        end
    end
endmodule

// File: rtl/cp_sign_sync.sv
`timescale 1ns/1ps
module cp_sign_sync
    import cps_pkg::*;
#(
    parameter int NMAX   = 2048,
    parameter int LMAX   = 512,
    parameter int SRCH_W = 16,
    localparam int FLW   = $clog2(NMAX) + 1,
    localparam int CLW   = $clog2(LMAX) + 1,
    localparam int SUM_W = $clog2(LMAX + 1) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic              in_i_sgn,
    input  logic              in_q_sgn,
    input  logic [FLW-1:0]    fft_len,
    input  logic [CLW-1:0]    cp_len,
    input  logic [SRCH_W-1:0] search_len,
    output logic              done,
    output logic [SRCH_W-1:0] timing_est
);
    sync_state_t       state_q, state_d;
    logic [FLW-1:0]    fill_cnt;
    logic [SRCH_W-1:0] eval_cnt;
    logic              in_fill, in_search, take, eval_en;
    logic              last_fill, last_eval, drop;
    logic [1:0]        lag_smp;
    half_prod_t        prod;
    logic signed [SUM_W-1:0] sum_re, sum_im, nxt_re, nxt_im;
    logic [SUM_W-1:0]  mag_re, mag_im, metric;
    logic [SRCH_W-1:0] win_idx;
    logic              done_q;
    logic [SRCH_W-1:0] est_q;

    assign in_fill   = (state_q == ST_FILL);
    assign in_search = (state_q == ST_SEARCH);
    assign take      = in_valid && !start && (in_fill || in_search);
    assign eval_en   = in_valid && !start && in_search;
    assign last_fill = (fill_cnt == (fft_len - 1'b1));
    assign last_eval = (eval_cnt == (search_len - 1'b1));
    assign drop      = (eval_cnt >= SRCH_W'(cp_len));

    cps_delay #(.DEPTH(NMAX)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .push (take),
        .len  (fft_len),
        .din  ({in_i_sgn, in_q_sgn}),
        .dout (lag_smp)
    );

    assign prod = sign_corr(in_i_sgn, in_q_sgn, lag_smp[1], lag_smp[0]);

    cps_movsum #(.LMAX(LMAX)) u_movsum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .push  (eval_en),
        .drop  (drop),
        .len   (cp_len),
        .prod  (prod),
        .sum_re(sum_re),
        .sum_im(sum_im),
        .nxt_re(nxt_re),
        .nxt_im(nxt_im)
    );

    assign mag_re = nxt_re[SUM_W-1] ? -nxt_re : nxt_re;
    assign mag_im = nxt_im[SUM_W-1] ? -nxt_im : nxt_im;
    assign metric = mag_re + mag_im;

    cps_peak #(.MW(SUM_W), .IW(SRCH_W)) u_peak (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .eval   (eval_en),
        .metric (metric),
        .idx    (eval_cnt),
        .win_idx(win_idx)
    );

    // next-state: arm, primed, finish, restart
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FILL;
            ST_FILL:   if (start) state_d = ST_FILL;
                       else if (in_valid && last_fill) state_d = ST_SEARCH;
            ST_SEARCH: if (start) state_d = ST_FILL;
                       else if (eval_en && last_eval) state_d = ST_DONE;
            ST_DONE:   if (start) state_d = ST_FILL;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            fill_cnt <= '0;
            eval_cnt <= '0;
        end else begin
            if (take && in_fill) fill_cnt <= fill_cnt + 1'b1;
            if (eval_en)         eval_cnt <= eval_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            est_q  <= '0;
        end else begin
            done_q <= eval_en && last_eval;
            if (eval_en && last_eval) est_q <= win_idx;
        end
    end

    assign done       = done_q;
    assign timing_est = est_q;
endmodule

// File: rtl/cps_checker.sv
`timescale 1ns/1ps
module cps_checker
    import cps_pkg::*;
#(
    parameter int SW  = 12,
    parameter int CLW = 10,
    parameter int EW  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 done,
    input logic [EW-1:0]        timing_est,
    input sync_state_t          state,
    input logic signed [SW-1:0] sum_re,
    input logic signed [SW-1:0] sum_im,
    input logic [CLW-1:0]       win_len
);
    logic signed [SW-1:0] lim;
    assign lim = $signed({{(SW-CLW){1'b0}}, win_len});

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_est_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_est != $past(timing_est)) |-> done);

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_FILL));

    p_done_after_search_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_SEARCH));

    p_sum_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH) |-> ((sum_re <= lim) && (sum_re >= -lim)
                                  && (sum_im <= lim) && (sum_im >= -lim)));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_DONE) && !start) |=> !done);
endmodule

bind cp_sign_sync cps_checker #(.SW(SUM_W), .CLW(CLW), .EW(SRCH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .timing_est(timing_est),
    .state     (state_q),
    .sum_re    (sum_re),
    .sum_im    (sum_im),
    .win_len   (cp_len)
);

// File: tb/tb_cp_sign_sync.sv
`timescale 1ns/1ps
module tb_cp_sign_sync;
    localparam int NMAX = 2048;
    localparam int LMAX = 512;
    localparam int SW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, in_valid = 1'b0, in_i = 1'b0, in_q = 1'b0;
    logic [$clog2(NMAX):0] fft_len = '0;
    logic [$clog2(LMAX):0] cp_len = '0;
    logic [SW-1:0] search_len = '0;
    logic done;
    logic [SW-1:0] timing_est;

    always #10 clk = ~clk;   // 50 MHz

    cp_sign_sync #(.NMAX(NMAX), .LMAX(LMAX), .SRCH_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_i_sgn(in_i), .in_q_sgn(in_q), .fft_len(fft_len), .cp_len(cp_len),
        .search_len(search_len), .done(done), .timing_est(timing_est));

    int n_vec = 0, n_bad = 0;
    int exp_q[$];
    bit s_i [0:4095];
    bit s_q [0:4095];
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // independent reference: full complex arithmetic on +/-1 values
    function automatic int ref_peak(input int n, input int l, input int s);
        int best = -1;
        int bidx = 0;
        for (int j = 0; j < s; j++) begin
            int sr = 0;
            int si = 0;
            int met;
            for (int m = ((j - l + 1) < 0) ? 0 : (j - l + 1); m <= j; m++) begin
                int a = s_i[n+m] ? -1 : 1;
                int b = s_q[n+m] ? -1 : 1;
                int c = s_i[m] ? -1 : 1;
                int d = s_q[m] ? -1 : 1;
                sr += a * c + b * d;
                si += b * c - a * d;
            end
            met = (sr < 0 ? -sr : sr) + (si < 0 ? -si : si);
            if (met > best) begin
                best = met;
                bidx = j;
            end
        end
        return bidx;
    endfunction

    task automatic fill_random(input int len);
        for (int k = 0; k < len; k++) begin
            s_i[k] = 1'($urandom_range(0, 1));
            s_q[k] = 1'($urandom_range(0, 1));
        end
    endtask

    task automatic plant_cp(input int n, input int l, input int off);
        for (int k = 0; k < l; k++) begin
            s_i[off+k] = s_i[off+n+k];
            s_q[off+k] = s_q[off+n+k];
        end
    endtask

    task automatic begin_search(input int n, input int l, input int s);
        @(negedge clk);
        start = 1'b1; in_valid = 1'b1; in_i = 1'b1; in_q = 1'b0;  // discarded sample
        fft_len = ($clog2(NMAX)+1)'(n);
        cp_len = ($clog2(LMAX)+1)'(l);
        search_len = SW'(s);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int count, input bit gaps);
        for (int k = 0; k < count; k++) begin
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; in_i = s_i[k]; in_q = s_q[k];
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic run_search(input int n, input int l, input int s, input bit gaps,
                              input int exp, input string tag);
        exp_q.push_back(exp);
        begin_search(n, l, s);
        feed(n + s, gaps);
        chk(done == 1'b1, {tag, " R6 done in cycle after last sample"}, int'(done), 1);
        chk(int'(timing_est) == exp, {tag, " R6 estimate present with done"}, int'(timing_est), exp);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R6 done lasts one cycle"}, int'(done), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected done", int'(timing_est), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(timing_est) == e, "R5 scoreboard peak index", int'(timing_est), e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done low after reset", int'(done), 0);
        chk(timing_est == '0, "R1 estimate zero after reset", int'(timing_est), 0);
        rst_n = 1'b1;

        // R9: samples before any start are ignored
        fill_random(64);
        feed(40, 1'b0);
        @(negedge clk);
        chk(done == 1'b0, "R9 no done without start", int'(done), 0);
        chk(timing_est == '0, "R9 estimate untouched before start", int'(timing_est), 0);

        // R3 / R10: planted prefix, lag 64
        fill_random(264);
        plant_cp(64, 16, 37);
        e = ref_peak(64, 16, 200);
        run_search(64, 16, 200, 1'b0, e, "R3 R10 fft64 planted prefix");

        // R9: samples after completion are ignored
        fill_random(64);
        feed(50, 1'b0);
        @(negedge clk);
        chk(done == 1'b0, "R9 no done after completion", int'(done), 0);
        chk(int'(timing_est) == e, "R9 estimate held after completion", int'(timing_est), e);

        // R7 / R10: lag 128 with valid gaps
        fill_random(278);
        plant_cp(128, 8, 90);
        e = ref_peak(128, 8, 150);
        run_search(128, 8, 150, 1'b1, e, "R7 R10 fft128 with gaps");

        // R5: constant stream, metric plateaus at window length -> earliest index L-1
        for (int k = 0; k < 200; k++) begin s_i[k] = 1'b0; s_q[k] = 1'b0; end
        run_search(64, 16, 40, 1'b0, 15, "R5 tie keeps earliest");
        // last evaluation is the new peak in the latch cycle
        run_search(64, 16, 16, 1'b0, 15, "R5 peak on final evaluation");

        // R2: stream rotated by +90 degrees each lag: purely imaginary products
        fill_random(64);
        for (int k = 64; k < 200; k++) begin
            s_i[k] = ~s_q[k-64];
            s_q[k] = s_i[k-64];
        end
        run_search(64, 12, 30, 1'b0, 11, "R2 imaginary product");

        // R4: single-sample window
        fill_random(200);
        e = ref_peak(64, 1, 30);
        run_search(64, 1, 30, 1'b0, e, "R4 window of one");

        // R6: one evaluation only
        fill_random(200);
        run_search(64, 4, 1, 1'b0, 0, "R6 single evaluation");

        // R8: abort mid-search, restart with a new search
        fill_random(400);
        begin_search(128, 16, 100);
        feed(128 + 20, 1'b0);
        plant_cp(128, 16, 60);
        e = ref_peak(128, 16, 100);
        run_search(128, 16, 100, 1'b1, e, "R8 restart after abort");

        // R4: longer window, lag 256
        fill_random(600);
        plant_cp(256, 32, 150);
        e = ref_peak(256, 32, 300);
        run_search(256, 32, 300, 1'b0, e, "R4 R10 fft256 window32");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 every expected result delivered", exp_q.size(), 0);
        report();
    end
endmodule